// File: doc/BRIEF.md
# Memory-backed 3-bit serializer

This block holds a 64-word by 8-bit synchronous dual-port memory. A host fills the memory through an address bus, a data bus and an active-low write strobe. A single-cycle start pulse then makes the block read the memory from address 0 upward.

The memory contents are handled as one continuous bit stream. Bit `i` of the stream is bit `i mod 8` of word `i / 8`. The stream leaves the block three bits per clock with the lowest bits first, and output groups freely straddle word boundaries. The 512 stored bits form 171 groups. The last group carries only two real bits, and its top bit is zero.

A valid flag marks each emitted group. A one-cycle done flag follows the last group, and the block then returns to idle, ready for new writes and another start.

Top module: `ser3_stream_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `grp_vld`, `done` and `grp_out` are all 0.
- R2: While the block is idle, a low `wr_n` stores `wr_data` into the word at `wr_addr` on the rising clock edge.
- R3: A start pulse sampled while idle begins readout at address 0. The first group appears with `grp_vld` high exactly two clocks after the edge that samples start.
- R4: Group k carries stream bits 3k, 3k+1 and 3k+2 on `grp_out[0]`, `grp_out[1]` and `grp_out[2]`. For example, group 2 is word1[0] on bit 2 and word0[7:6] on bits 1:0.
- R5: A run emits exactly 171 groups with `grp_vld` high on consecutive cycles, with no gap.
- R6: The last group (index 170) carries word63[7:6] on `grp_out[1:0]`, and `grp_out[2]` is 0.
- R7: `done` is high for exactly one cycle, the cycle right after the last valid group, and `grp_vld` is low in that cycle.
- R8: `grp_out` is 0 in every cycle where `grp_vld` is low.
- R9: A start pulse during readout neither restarts nor extends the run. The stream stays at 171 groups and ends with a single done pulse.
- R10: Write strobes during readout leave the memory unchanged. A following run reads the earlier contents.
- R11: After done, the block accepts new writes and a new start, and streams the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_addr | input | 6 | Write word address |
| wr_data | input | 8 | Write data |
| wr_n | input | 1 | Active-low write strobe |
| start | input | 1 | One-cycle readout start pulse |
| grp_out | output | 3 | Current 3-bit group |
| grp_vld | output | 1 | Group valid |
| done | output | 1 | One-cycle pulse after the last group |

## Verification
The hardest situation to reach is a group that straddles a word boundary. It has to be emitted in the same cycle that a freshly fetched word lands in the bit buffer. That is where a late memory fetch would show up as a gap or a wrong bit.

The bench streams full contents in three runs: an address-derived pattern, the same pattern again after writes were attempted mid-run, and an all-ones pattern with word 0 cleared. A scoreboard compares all 171 groups of each run. Counting the span from the first valid group to done exposes any stall in the fetch timing.

A start pulse and write strobes are injected deep inside a run. This shows at the outputs that neither the stream nor the stored data moves.

// File: rtl/ser3_pkg.sv
package ser3_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_FINISH = 2'd2
  } ser_state_t;
endpackage

// File: rtl/ser3_rst_sync.sv
module ser3_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/ser3_dpram.sv
module ser3_dpram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  // write port
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // read port, one cycle latency
  always_ff @(posedge clk) begin
    if (re) begin
      rdata_q <= mem[raddr];
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/ser3_ctrl.sv
module ser3_ctrl
  import ser3_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int GRP_W  = 3,
  parameter int LVL_W  = 4,
  localparam int DEPTH   = 1 << ADDR_W,
  localparam int NUM_GRP = (DEPTH * DATA_W + GRP_W - 1) / GRP_W,
  localparam int CNT_W   = ADDR_W + 1,
  localparam int GC_W    = $clog2(NUM_GRP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LVL_W-1:0]  lvl,
  input  logic [LVL_W-1:0]  lvl_next,
  output logic              busy,
  output logic              clear,
  output logic              emit,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              word_vld,
  output logic              done
);
  localparam logic [CNT_W-1:0] DEPTH_C   = CNT_W'(DEPTH);
  localparam logic [GC_W-1:0]  LAST_GRP  = GC_W'(NUM_GRP - 1);
  localparam logic [LVL_W-1:0] GRP_L     = LVL_W'(GRP_W);
  localparam logic [LVL_W-1:0] REFILL_L  = LVL_W'(2 * GRP_W);

  ser_state_t       st_q, st_d;
  logic [CNT_W-1:0] req_q, req_d;
  logic [GC_W-1:0]  grp_q, grp_d;
  logic             rvld_q, rvld_d;
  logic             done_q, done_d;
  logic             all_rcvd, last_grp;

  // next-state logic
  always_comb begin
    st_d     = st_q;
    req_d    = req_q;
    grp_d    = grp_q;
    done_d   = 1'b0;
    clear    = 1'b0;
    rd_en    = 1'b0;
    rd_addr  = req_q[ADDR_W-1:0];
    all_rcvd = (req_q == DEPTH_C) && !rvld_q;
    emit     = 1'b0;
    last_grp = 1'b0;
    case (st_q)
      ST_IDLE: begin
        rd_addr = '0;
        if (start) begin
          clear = 1'b1;
          rd_en = 1'b1;
          req_d = CNT_W'(1);
          grp_d = '0;
          st_d  = ST_RUN;
        end
      end
      ST_RUN: begin
        emit     = (lvl >= GRP_L) || (all_rcvd && (lvl != '0));
        last_grp = emit && (grp_q == LAST_GRP);
        rd_en    = (req_q < DEPTH_C) && (lvl_next < REFILL_L);
        if (rd_en) begin
          req_d = req_q + CNT_W'(1);
        end
        if (emit) begin
          grp_d = grp_q + GC_W'(1);
        end
        if (last_grp) begin
          st_d = ST_FINISH;
        end
      end
      ST_FINISH: begin
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    rvld_d = rd_en;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      req_q  <= '0;
      grp_q  <= '0;
      rvld_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      req_q  <= req_d;
      grp_q  <= grp_d;
      rvld_q <= rvld_d;
      done_q <= done_d;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign word_vld = rvld_q;
  assign done     = done_q;

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_done_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (grp_q == GC_W'(NUM_GRP)));
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && start) |=> (st_q != ST_IDLE));
  assert_start_no_rewind_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && start) |=> (grp_q >= $past(grp_q)));
  assert_fetch_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && rd_en) |-> (req_q < DEPTH_C));
endmodule

// File: rtl/ser3_packer.sv
module ser3_packer #(
  parameter int DATA_W = 8,
  parameter int GRP_W  = 3,
  parameter int BUF_W  = DATA_W + 2 * GRP_W,
  parameter int LVL_W  = $clog2(BUF_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              emit,
  input  logic              word_vld,
  input  logic [DATA_W-1:0] word,
  output logic [LVL_W-1:0]  lvl,
  output logic [LVL_W-1:0]  lvl_next,
  output logic [GRP_W-1:0]  dout,
  output logic              dout_vld
);
  localparam logic [LVL_W-1:0] GRP_L  = LVL_W'(GRP_W);
  localparam logic [LVL_W-1:0] DATA_L = LVL_W'(DATA_W);
  localparam logic [LVL_W-1:0] MAX_L  = LVL_W'(BUF_W);

  logic [BUF_W-1:0] sbuf_q, sbuf_d, base_buf, ext_word;
  logic [LVL_W-1:0] lvl_q, lvl_d, base_lvl;
  logic [GRP_W-1:0] grp, out_q;
  logic             vld_q;

  // next-state logic: drain one group, then append the arriving word
  always_comb begin
    base_buf = emit ? (sbuf_q >> GRP_W) : sbuf_q;
    if (!emit) begin
      base_lvl = lvl_q;
    end else if (lvl_q > GRP_L) begin
      base_lvl = lvl_q - GRP_L;
    end else begin
      base_lvl = '0;
    end
    ext_word = BUF_W'(word) << base_lvl;
    sbuf_d   = base_buf;
    lvl_d    = base_lvl;
    if (word_vld) begin
      sbuf_d = base_buf | ext_word;
      lvl_d  = base_lvl + DATA_L;
    end
    if (clear) begin
      sbuf_d = '0;
      lvl_d  = '0;
    end
  end

  // zero any bit position beyond the filled level
  for (genvar j = 0; j < GRP_W; j++) begin : g_mask
    assign grp[j] = sbuf_q[j] & (lvl_q > LVL_W'(j));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sbuf_q <= '0;
      lvl_q  <= '0;
      out_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      sbuf_q <= sbuf_d;
      lvl_q  <= lvl_d;
      vld_q  <= emit;
      if (emit) begin
        out_q <= grp;
      end else begin
        out_q <= '0;
      end
    end
  end

  assign lvl      = lvl_q;
  assign lvl_next = lvl_d;
  assign dout     = out_q;
  assign dout_vld = vld_q;

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> (lvl_q != '0));
  assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_q <= MAX_L);
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> (out_q == '0));
endmodule

// File: rtl/ser3_stream_top.sv
module ser3_stream_top #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int GRP_W  = 3,
  localparam int BUF_W = DATA_W + 2 * GRP_W,
  localparam int LVL_W = $clog2(BUF_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_n,
  input  logic              start,
  output logic [GRP_W-1:0]  grp_out,
  output logic              grp_vld,
  output logic              done
);
  logic              rst_n_s;
  logic              busy, clear, emit, rd_en, word_vld, mem_we;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic [LVL_W-1:0]  lvl, lvl_next;

  ser3_rst_sync u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_s)
  );

  // host writes land only while idle
  assign mem_we = !wr_n && !busy && rst_n_s;

  ser3_dpram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .waddr(wr_addr),
    .wdata(wr_data),
    .re   (rd_en),
    .raddr(rd_addr),
    .rdata(rd_data)
  );

  ser3_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GRP_W(GRP_W), .LVL_W(LVL_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .start   (start),
    .lvl     (lvl),
    .lvl_next(lvl_next),
    .busy    (busy),
    .clear   (clear),
    .emit    (emit),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .word_vld(word_vld),
    .done    (done)
  );

  ser3_packer #(.DATA_W(DATA_W), .GRP_W(GRP_W), .BUF_W(BUF_W), .LVL_W(LVL_W)) u_pack (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clear   (clear),
    .emit    (emit),
    .word_vld(word_vld),
    .word    (rd_data),
    .lvl     (lvl),
    .lvl_next(lvl_next),
    .dout    (grp_out),
    .dout_vld(grp_vld)
  );

  assert_done_not_valid_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> !grp_vld);
endmodule

// File: tb/ser3_stream_top_tb.sv
module ser3_stream_top_tb;
  localparam int NUM_GRP = 171;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       wr_n = 1'b1;
  logic       start = 1'b0;
  logic [2:0] grp_out;
  logic       grp_vld;
  logic       done;

  int total = 0;
  int bad = 0;
  logic [7:0] model [64];
  logic [2:0] exp_q [$];
  int  cyc = 0, first_cyc = 0, run_grp = 0, done_cnt = 0;
  bit  prev_vld = 1'b0, mon_en = 1'b0;

  always #4 clk = ~clk;

  ser3_stream_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_n(wr_n), .start(start), .grp_out(grp_out), .grp_vld(grp_vld), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_word(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_addr = 6'(a); wr_data = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
  endtask

  function automatic logic stream_bit(input int i);
    if (i >= 512) return 1'b0;
    return model[i / 8][i % 8];
  endfunction

  // driver: queue expected groups, pulse start, optionally disturb the run
  task automatic run_once(input int disturb);
    int d0;
    for (int k = 0; k < NUM_GRP; k++) begin
      exp_q.push_back({stream_bit(3*k+2), stream_bit(3*k+1), stream_bit(3*k)});
    end
    d0 = done_cnt;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(grp_vld == 1'b0, "R3 early valid", int'(grp_vld), 0);
    @(negedge clk);
    chk(grp_vld == 1'b0, "R3 early valid", int'(grp_vld), 0);
    @(negedge clk);
    chk(grp_vld == 1'b1, "R3 first valid", int'(grp_vld), 1);
    repeat (30) @(negedge clk);
    if (disturb == 1) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end else if (disturb == 2) begin
      for (int a = 60; a < 64; a++) begin
        wr_addr = 6'(a); wr_data = 8'h3C; wr_n = 1'b0;
        @(negedge clk);
      end
      wr_n = 1'b1;
    end
    wait (done_cnt != d0);
    repeat (5) @(negedge clk);
    chk(done_cnt == d0 + 1, "R9 single done", done_cnt - d0, 1);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_en) begin
      cyc++;
      if (grp_vld) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 extra group", int'(grp_out), -1);
        end else begin
          logic [2:0] e;
          e = exp_q.pop_front();
          if (run_grp == NUM_GRP - 1)
            chk(grp_out == e, "R6 last group", int'(grp_out), int'(e));
          else
            chk(grp_out == e, "R4 group data", int'(grp_out), int'(e));
        end
        run_grp++;
        if (run_grp == 1) first_cyc = cyc;
      end else begin
        chk(grp_out == 3'd0, "R8 idle output", int'(grp_out), 0);
      end
      if (done) begin
        done_cnt++;
        chk(prev_vld && !grp_vld, "R7 done placement", int'(prev_vld), 1);
        chk(run_grp == NUM_GRP, "R5 group count", run_grp, NUM_GRP);
        chk(cyc - first_cyc == NUM_GRP, "R5 no gap", cyc - first_cyc, NUM_GRP);
        chk(exp_q.size() == 0, "R5 leftover", exp_q.size(), 0);
        run_grp = 0;
      end
      prev_vld = grp_vld;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(grp_vld == 0 && done == 0 && grp_out == 0, "R1 in reset", int'(grp_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(grp_vld == 0 && done == 0 && grp_out == 0, "R1 after reset", int'(grp_vld), 0);
    repeat (3) @(negedge clk);
    mon_en = 1'b1;
    // R2: fill with an address-derived pattern
    for (int a = 0; a < 64; a++) begin
      model[a] = 8'((a * 37 + 5) & 8'hFF);
      write_word(a, model[a]);
    end
    run_once(1);   // R9: start pulse mid-run
    run_once(2);   // R10: writes mid-run must not stick
    // R11: new contents, all ones except word 0 cleared
    for (int a = 0; a < 64; a++) begin
      model[a] = (a == 0) ? 8'h00 : 8'hFF;
      write_word(a, model[a]);
    end
    run_once(0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule